// File: doc/BRIEF.md
# Line-Change Timestamping Engine

This block watches a number of 32-line input groups ("slices") and records the moment at which enabled lines in a slice change level. Each time the enabled part of a slice differs from the value last recorded for it, the block writes one entry into an event queue. The entry holds the value of a free-running 64-bit tick counter, the slice number, and the masked line values of the slice before and after the change. Software takes the XOR of the two values to find the lines that moved. It forms a global line number as slice times 32 plus bit position.

Software reaches the block over a simple 32-bit register bus. Writes complete in one clock and reads are combinational. Through this bus it sets the global and interrupt enables and the queue threshold, and writes a line mask for each slice. It reads the head entry word by word, retires that entry with a pop command, and reads a status word with the queue occupancy and a sticky overflow flag. A level interrupt stays high while occupancy is at or above the programmed threshold.

Top module: `lcs_top`

## Requirements
- R1: After reset the control word, every slice mask and the status word read 0, and `irq_o` is low.
- R2: With the global enable set, a change on a line whose mask bit is 1 creates one entry, visible after the next clock edge. The slice number reads in bits 23:16 of offset 0x0C. The masked new value reads at 0x10 and the masked old value at 0x14. A change on a line whose mask bit is 0, or a change of a mask, creates no entry.
- R3: When several slices change in the same cycle, one entry is written per cycle, the lowest slice number first.
- R4: The tick counter is 0 after reset and adds 1 on every clock. An entry holds the counter value of the cycle in which it is written. The upper word reads at 0x04 and the lower word at 0x08.
- R5: Status (0x20) bits 15:8 hold the number of queued entries.
- R6: Writing 1 in bit 0 of the command word (0x1C) removes the head entry. A pop on an empty queue changes nothing.
- R7: When the queue is full, new events are discarded and status bit 0 is set. That bit stays set until software writes 1 to status bit 0, which leaves the queue contents unchanged.
- R8: `irq_o` is high exactly when the interrupt enable (control bit 1) is set and the occupancy is at least the threshold in control bits 15:8. A threshold of 0 acts as 1.
- R9: With control bit 0 clear, no entries are created. Line changes made while disabled are not reported after the enable is set again.
- R10: The mask of slice N is read and written at 0x40 + 0x20*N. Bit k enables line k of that slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also advances the tick counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | SLICES*32 | Line levels, already synchronised. Slice N occupies bits 32N+31:32N |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_we_i | input | 1 | Write strobe, one write per clock |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt on occupancy threshold |

## Verification
The assertions assume that the line inputs are already synchronous to `clk`. They also assume that software issues at most one bus write per cycle, so a pop and an overflow clear never collide with another write. The stimulus changes lines and bus signals only on the falling edge. It leaves the lines still for several cycles after each burst, so every pending slice is granted before the next change. Masks are rewritten only between bursts, and the random pattern mixes dense and sparse masks so that both masked and unmasked changes occur.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    localparam int LINE_W  = 32;
    localparam int TS_W    = 64;
    localparam int SLICE_W = 8;

    typedef struct packed {
        logic [TS_W-1:0]    ts;
        logic [SLICE_W-1:0] slice;
        logic [LINE_W-1:0]  prev;
        logic [LINE_W-1:0]  cur;
    } lcs_entry_t;
endpackage

// File: rtl/lcs_scan.sv
module lcs_scan
    import lcs_pkg::*;
#(
    parameter int SLICES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SLICES-1:0][LINE_W-1:0]  lines_i,
    input  logic [SLICES-1:0][LINE_W-1:0]  mask_i,
    input  logic                           en_i,
    input  logic                           full_i,
    output logic                           push_o,
    output logic                           drop_o,
    output logic [SLICE_W-1:0]             slice_o,
    output logic [LINE_W-1:0]              prev_o,
    output logic [LINE_W-1:0]              cur_o
);
    localparam int IDX_W = (SLICES > 1) ? $clog2(SLICES) : 1;

    typedef struct packed {
        logic [SLICES-1:0][LINE_W-1:0] prev;
    } scan_st_t;

    scan_st_t st_q, st_d;
    logic [SLICES-1:0][LINE_W-1:0] diff;
    logic             found;
    logic [IDX_W-1:0] gsel;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        gsel  = '0;
        for (int s = 0; s < SLICES; s++) begin
            diff[s] = (lines_i[s] ^ st_q.prev[s]) & mask_i[s];
        end
        for (int s = 0; s < SLICES; s++) begin
            if (!found && (diff[s] != '0)) begin
                found = 1'b1;
                gsel  = IDX_W'(s);
            end
        end
        for (int s = 0; s < SLICES; s++) begin
            if (en_i) begin
                st_d.prev[s] = (st_q.prev[s] & mask_i[s]) | (lines_i[s] & ~mask_i[s]);
            end else begin
                st_d.prev[s] = lines_i[s];
            end
        end
        if (en_i && found) begin
            st_d.prev[gsel] = lines_i[gsel];
        end
        push_o  = en_i && found && !full_i;
        drop_o  = en_i && found && full_i;
        slice_o = SLICE_W'(gsel);
        prev_o  = st_q.prev[gsel] & mask_i[gsel];
        cur_o   = lines_i[gsel] & mask_i[gsel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_entry_changed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (prev_o != cur_o));

    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!push_o && !drop_o));
endmodule

// File: rtl/lcs_fifo.sv
module lcs_fifo
    import lcs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  lcs_entry_t                   entry_i,
    input  logic                         pop_i,
    output lcs_entry_t                   head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   st_q, st_d;
    lcs_entry_t mem_q [DEPTH];
    logic       do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= entry_i;
        end
    end

    assign head_o  = (st_q.cnt != '0) ? mem_q[st_q.rd] : '0;
    assign count_o = st_q.cnt;
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));

    p_push_not_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (count_o == '0) && !push_i) |=> (count_o == '0));
endmodule

// File: rtl/lcs_top.sv
module lcs_top
    import lcs_pkg::*;
#(
    parameter int SLICES = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLICES*LINE_W-1:0] lines_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_we_i,
    input  logic [31:0]              bus_wdata_i,
    output logic [31:0]              bus_rdata_o,
    output logic                     irq_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_TSH  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_TSL  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_PREV = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h20);
    localparam int MASK_BASE = 'h40;
    localparam int MASK_STEP = 'h20;

    typedef struct packed {
        logic                          en;
        logic                          ie;
        logic [7:0]                    thr;
        logic                          ovf;
        logic [TS_W-1:0]               ts;
        logic [SLICES-1:0][LINE_W-1:0] mask;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [SLICES-1:0][LINE_W-1:0] lines_v;
    logic              sc_push, sc_drop;
    logic [SLICE_W-1:0] sc_slice;
    logic [LINE_W-1:0] sc_prev, sc_cur;
    lcs_entry_t        new_entry, head;
    logic [CNT_W-1:0]  occ;
    logic              q_full;
    logic              pop_req, ovf_clr;
    logic [7:0]        occ8, thr_eff;
    logic              unused_bits;

    assign lines_v     = lines_i;
    assign unused_bits = ^{bus_wdata_i[31:16], bus_wdata_i[7:2]};

    assign new_entry.ts    = st_q.ts;
    assign new_entry.slice = sc_slice;
    assign new_entry.prev  = sc_prev;
    assign new_entry.cur   = sc_cur;

    lcs_scan #(.SLICES(SLICES)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines_v),
        .mask_i  (st_q.mask),
        .en_i    (st_q.en),
        .full_i  (q_full),
        .push_o  (sc_push),
        .drop_o  (sc_drop),
        .slice_o (sc_slice),
        .prev_o  (sc_prev),
        .cur_o   (sc_cur)
    );

    lcs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (sc_push),
        .entry_i (new_entry),
        .pop_i   (pop_req),
        .head_o  (head),
        .count_o (occ),
        .full_o  (q_full)
    );

    assign pop_req = bus_we_i && (bus_addr_i == A_CMD) && bus_wdata_i[0];
    assign ovf_clr = bus_we_i && (bus_addr_i == A_STAT) && bus_wdata_i[0];

    always_comb begin
        st_d    = st_q;
        st_d.ts = st_q.ts + 1'b1;
        if (bus_we_i && (bus_addr_i == A_CTRL)) begin
            st_d.en  = bus_wdata_i[0];
            st_d.ie  = bus_wdata_i[1];
            st_d.thr = bus_wdata_i[15:8];
        end
        for (int s = 0; s < SLICES; s++) begin
            if (bus_we_i && (bus_addr_i == ADDR_W'(MASK_BASE + s * MASK_STEP))) begin
                st_d.mask[s] = bus_wdata_i;
            end
        end
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (sc_drop) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ8    = 8'(occ);
    assign thr_eff = (st_q.thr == 8'd0) ? 8'd1 : st_q.thr;
    assign irq_o   = st_q.ie && (occ8 >= thr_eff);

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            A_CTRL: bus_rdata_o = {16'd0, st_q.thr, 6'd0, st_q.ie, st_q.en};
            A_TSH:  bus_rdata_o = head.ts[63:32];
            A_TSL:  bus_rdata_o = head.ts[31:0];
            A_SRC:  bus_rdata_o = {8'd0, head.slice, 16'd0};
            A_CUR:  bus_rdata_o = head.cur;
            A_PREV: bus_rdata_o = head.prev;
            A_STAT: bus_rdata_o = {16'd0, occ8, 7'd0, st_q.ovf};
            default: bus_rdata_o = '0;
        endcase
        for (int s = 0; s < SLICES; s++) begin
            if (bus_addr_i == ADDR_W'(MASK_BASE + s * MASK_STEP)) begin
                bus_rdata_o = st_q.mask[s];
            end
        end
    end

    p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st_q.ie);

    p_drop_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_drop |-> q_full);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf);

    p_stamp_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.ts != $past(st_q.ts)));
endmodule

// File: tb/sim_lcs_top.sv
module sim_lcs_top;
    localparam int NS    = 4;
    localparam int DEPTH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS*32-1:0] lines = '0;
    logic [7:0]     addr = '0;
    logic           we = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [63:0] cyc;

    logic [63:0] m_ts   [DEPTH];
    logic [31:0] m_sl   [DEPTH];
    logic [31:0] m_prev [DEPTH];
    logic [31:0] m_cur  [DEPTH];
    int          m_n;
    bit          m_ovf;
    logic [31:0] masks [NS];

    lcs_top #(.SLICES(NS), .DEPTH(DEPTH), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] occ_of(input logic [31:0] st);
        return {24'd0, st[15:8]};
    endfunction

    // drive all slices at one falling edge and model the entries that follow
    task automatic burst(input logic [NS*32-1:0] nl);
        int rank;
        @(negedge clk);
        rank = 0;
        for (int s = 0; s < NS; s++) begin
            logic [31:0] o, n;
            o = lines[s*32 +: 32];
            n = nl[s*32 +: 32];
            if (((o ^ n) & masks[s]) != 0) begin
                if (m_n < DEPTH) begin
                    m_ts[m_n]   = cyc + 64'(rank);
                    m_sl[m_n]   = 32'(s);
                    m_prev[m_n] = o & masks[s];
                    m_cur[m_n]  = n & masks[s];
                    m_n++;
                end else begin
                    m_ovf = 1'b1;
                end
                rank++;
            end
        end
        lines = nl;
        idle(NS + 2);
    endtask

    task automatic drain_check(input string tag);
        logic [31:0] st, hi, lo, src, cu, pv;
        rd(8'h20, st);
        chk({tag, " R5 occupancy"}, occ_of(st), 32'(m_n));
        chk({tag, " R7 overflow flag"}, st[0], m_ovf);
        for (int i = 0; i < m_n; i++) begin
            rd(8'h04, hi); rd(8'h08, lo);
            chk({tag, " R4 stamp"}, {hi, lo}, m_ts[i]);
            rd(8'h0C, src);
            chk({tag, " R3 slice order"}, src, m_sl[i] << 16);
            rd(8'h10, cu);
            chk({tag, " R2 current"}, cu, m_cur[i]);
            rd(8'h14, pv);
            chk({tag, " R2 previous"}, pv, m_prev[i]);
            wr(8'h1C, 32'h1);
        end
        rd(8'h20, st);
        chk({tag, " R6 emptied"}, occ_of(st), 32'd0);
        if (st[0]) wr(8'h20, 32'h1);
        m_n = 0;
        m_ovf = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st, hi, lo;
        logic [NS*32-1:0] nl;
        logic [63:0] c0;
        int seed;
        seed = $urandom(32'd1357);
        m_n = 0;
        m_ovf = 1'b0;
        for (int s = 0; s < NS; s++) masks[s] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd(8'h00, v); chk("R1 control", v, 0);
        rd(8'h20, v); chk("R1 status", v, 0);
        for (int s = 0; s < NS; s++) begin
            rd(8'(8'h40 + 8'h20 * s), v); chk("R1 mask", v, 0);
        end
        chk("R1 irq", irq, 0);

        // R10 mask placement and readback
        for (int s = 0; s < NS; s++) wr(8'(8'h40 + 8'h20 * s), 32'hA5000000 | 32'(s));
        for (int s = 0; s < NS; s++) begin
            rd(8'(8'h40 + 8'h20 * s), v); chk("R10 mask readback", v, 32'hA5000000 | 32'(s));
        end

        // R2 / R4 single directed event on slice 1
        wr(8'h40 + 8'h20, 32'h0000_00FF);
        masks[1] = 32'h0000_00FF;
        wr(8'h00, 32'h1);
        @(negedge clk);
        c0 = cyc;
        lines[32 + 5] = 1'b1;
        idle(2);
        rd(8'h20, st); chk("R5 one entry", occ_of(st), 1);
        rd(8'h0C, v);  chk("R2 slice field", v, 32'h0001_0000);
        rd(8'h10, v);  chk("R2 cur", v, 32'h20);
        rd(8'h14, v);  chk("R2 prev", v, 0);
        rd(8'h04, hi); rd(8'h08, lo);
        chk("R4 stamp", {hi, lo}, c0);
        wr(8'h1C, 32'h1);
        // masked line change: no entry
        @(negedge clk); lines[32 + 20] = 1'b1; idle(3);
        rd(8'h20, st); chk("R2 masked line ignored", occ_of(st), 0);
        // mask change alone: no entry
        wr(8'h40 + 8'h20, 32'hFFFF_FFFF); masks[1] = 32'hFFFF_FFFF;
        idle(3);
        rd(8'h20, st); chk("R2 mask change silent", occ_of(st), 0);

        // R6 pop on empty
        wr(8'h1C, 32'h1);
        rd(8'h20, st); chk("R6 pop empty", st, 0);

        // R7 overflow with slice 0 toggling
        wr(8'h40, 32'h1); masks[0] = 32'h1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            @(negedge clk); lines[0] = ~lines[0];
        end
        idle(2);
        rd(8'h20, st);
        chk("R7 full count", occ_of(st), DEPTH);
        chk("R7 overflow set", st[0], 1);
        wr(8'h20, 32'h1);
        rd(8'h20, st);
        chk("R7 overflow cleared", st[0], 0);
        chk("R7 clear keeps entries", occ_of(st), DEPTH);
        for (int i = 0; i < DEPTH; i++) wr(8'h1C, 32'h1);

        // R8 threshold interrupt
        wr(8'h00, 32'h0303);
        for (int i = 0; i < 2; i++) begin @(negedge clk); lines[0] = ~lines[0]; end
        idle(2);
        chk("R8 below threshold", irq, 0);
        @(negedge clk); lines[0] = ~lines[0];
        idle(2);
        chk("R8 at threshold", irq, 1);
        wr(8'h00, 32'h0003);
        wr(8'h1C, 32'h1); wr(8'h1C, 32'h1);
        chk("R8 zero threshold as one", irq, 1);
        wr(8'h00, 32'h0001);
        chk("R8 interrupt disabled", irq, 0);
        wr(8'h1C, 32'h1);
        rd(8'h20, st); chk("R8 drained", occ_of(st), 0);

        // R9 global disable
        wr(8'h00, 32'h0);
        @(negedge clk); lines[0] = ~lines[0]; idle(3);
        rd(8'h20, st); chk("R9 disabled no entry", occ_of(st), 0);
        wr(8'h00, 32'h1); idle(3);
        rd(8'h20, st); chk("R9 no stale report", occ_of(st), 0);
        v = {31'd0, lines[0]};
        @(negedge clk); lines[0] = ~lines[0]; idle(2);
        rd(8'h14, st); chk("R9 prev after re-enable", st, v);
        wr(8'h1C, 32'h1);

        // R3 directed multi-slice: slices 3, 0, 2 change together
        for (int s = 0; s < NS; s++) begin
            wr(8'(8'h40 + 8'h20 * s), 32'hFFFF_FFFF); masks[s] = 32'hFFFF_FFFF;
        end
        nl = lines;
        nl[3*32 +: 32] ^= 32'h8000_0001;
        nl[0 +: 32]    ^= 32'h0000_0100;
        nl[2*32 +: 32] ^= 32'h0001_0000;
        burst(nl);
        drain_check("directed");

        // random bursts with random masks (R2 R3 R4 R5 R6 R7)
        for (int r = 0; r < 30; r++) begin
            int nb;
            for (int s = 0; s < NS; s++) begin
                masks[s] = (r % 3 == 0) ? ($urandom & $urandom) : ($urandom | $urandom);
                wr(8'(8'h40 + 8'h20 * s), masks[s]);
            end
            nb = 1 + ($urandom % 3);
            for (int b = 0; b < nb; b++) begin
                nl = lines;
                for (int s = 0; s < NS; s++) begin
                    if ($urandom % 2 == 1) nl[s*32 +: 32] ^= ($urandom & $urandom);
                end
                burst(nl);
            end
            drain_check("random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule